// File: doc/BRIEF.md
# Multi-Channel Front-End Configuration Register Bank

This block holds the settings and status of a multi-channel front-end readout chip. Each channel has its own copy of a set of per-channel settings: eight filter coefficients, a zero-suppression threshold word, a zero-suppression shape word, a fixed pedestal, a noise value and a pedestal-memory data word. A single set of global settings covers the pedestal-memory address, two filter threshold words, the trigger window, the datapath mode word and the operating-mode flags. The block also keeps read-only status (a trigger counter, a bunch-crossing counter, sticky error flags and the chip address), and it decodes a few write-only command addresses.

A host reaches all of this over a simple bus. The bus carries an address, a channel number, a broadcast flag, a write enable with write data, and a read enable with registered read data. A broadcast write to a per-channel address loads every channel in one cycle. Global addresses refuse broadcast writes. For a command address, only the access matters and the data is discarded. All stored settings drive the datapath directly. A write to the pedestal-memory data address also produces a one-cycle write strobe, together with the address and data, for an external pedestal memory.

Top module: `fe_cfg_regbank`

## Requirements
- R1: After reset, the outputs hold these values. Every coefficient, pedestal and noise value is 0, and the pedestal-memory address is 0. Each channel's zero-suppression threshold word is 0x0000A. Each channel's zero-suppression shape word is 0x7E (glitch width 2 in [1:0], post-samples 7 in [4:2], pre-samples 3 in [6:5]). The filter threshold word is 0x40603. The trigger window word is 0x3FD00. The datapath mode word is 0. The mode flags word is 0xA4. The pedestal threshold word is 0x463.
- R2: A write without broadcast to a per-channel address updates only the channel named by the channel number. The result is visible on the outputs after the write's clock edge. Per-channel addresses are 0x00–0x07 for coefficients (poles 0–3, then zeros 4–7), 0x08 for the threshold, 0x09 for the shape, 0x0A for the pedestal, 0x0B for the noise and 0x0C for the pedestal-memory data.
- R3: A broadcast write to a per-channel address updates that register in every channel at the same clock edge, whatever the channel number.
- R4: A broadcast write to a global address leaves it unchanged. A write without broadcast updates it, keeping only the register's low bits. Global addresses are 0x0D for the pedestal-memory address (10 bits), 0x0E for the filter thresholds (20 bits), 0x0F for the trigger window (18 bits), 0x10 for the datapath mode (12 bits), 0x11 for the mode flags (8 bits) and 0x12 for the pedestal thresholds (14 bits).
- R5: The trigger window stores pre-samples in [7:0] and samples per event in [17:8]. A written pre-sample value above 191 is stored as 191, and a samples value above 1021 is stored as 1021.
- R6: A read returns data on the cycle after the read enable. Per-channel addresses read the register of the channel named by the channel number. Address 0x14 returns the 5-bit chip address input. Command addresses (0x1B–0x1F) and unused addresses (0x17–0x1A) read as 0. Bits above a register's width read as 0.
- R7: The 16-bit trigger counter (read at 0x13) counts trigger pulses, and the 20-bit bunch-crossing counter (read at 0x16) counts bunch-crossing pulses. Both wrap at full width. A write to 0x1C clears the trigger counter and a write to 0x1E clears the bunch-crossing counter. A clear wins over an increment in the same cycle.
- R8: The error word (read at 0x15) has three sticky flags: parity error in bit 0, instruction error in bit 1 and trigger overlap in bit 2. Each flag sets on its input pulse and stays set until a write to 0x1D or a reset. The clear wins over a set in the same cycle.
- R9: Writes to read-only addresses (0x13–0x16), to unused addresses and to 0x1B leave every stored value unchanged. A command write acts whatever its data value.
- R10: A write to 0x1F restores every register default and clears both counters and the error flags, at the write's clock edge, in the same way as the reset input.
- R11: A write to 0x0C raises the pedestal-memory write strobe for the one cycle after the write edge. During that cycle the strobe's data is the written low 10 bits and its address is the stored pedestal-memory address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_we | input | 1 | Host write enable |
| i_re | input | 1 | Host read enable |
| i_bcast | input | 1 | Broadcast flag for writes |
| i_chan | input | 2 | Channel number |
| i_addr | input | 5 | Register address |
| i_wdata | input | 20 | Write data |
| o_rdata | output | 20 | Registered read data |
| i_trig | input | 1 | Trigger pulse |
| i_bx | input | 1 | Bunch-crossing pulse |
| i_err_par | input | 1 | Parity error pulse |
| i_err_instr | input | 1 | Instruction error pulse |
| i_err_ovl | input | 1 | Trigger overlap pulse |
| i_chip_id | input | 5 | Chip address |
| o_coef | output | 416 | Filter coefficients, 8 × 13 bits per channel, channel-major |
| o_zs_thr | output | 80 | Zero-suppression threshold word per channel |
| o_zs_cfg | output | 28 | Zero-suppression shape word per channel |
| o_ped | output | 40 | Fixed pedestal per channel |
| o_noise | output | 40 | Noise value per channel |
| o_pm_addr | output | 10 | Pedestal-memory address |
| o_pm_data | output | 10 | Pedestal-memory write data |
| o_pm_we | output | 1 | Pedestal-memory write strobe |
| o_filt_thr | output | 20 | Filter threshold word |
| o_trig_cfg | output | 18 | Trigger window word |
| o_dp_cfg | output | 12 | Datapath mode word |
| o_mode | output | 8 | Mode flags |
| o_vp_thr | output | 14 | Pedestal threshold word |

## Verification
The bench makes addressed writes to one channel and reads the neighbouring channels back, which separates channel selection from broadcast. It then makes broadcast writes to both a per-channel and a global address, which shows whether the broadcast flag is honoured in one region and refused in the other. Counter and flag checks place a clear in the same cycle as an increment or a set, so that priority becomes visible. The trigger counter is also driven through a full 16-bit wrap. Over-limit trigger window values, writes to read-only, unused and command addresses, and a software reset after many changes show that clamping, ignored writes and default restoration each have their own effect.

// File: rtl/fe_cfg_pkg.sv
package fe_cfg_pkg;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 20;
    localparam int COEF_W   = 13;
    localparam int N_COEF   = 8;
    localparam int COEF_IW  = $clog2(N_COEF);
    localparam int ZTHR_W   = 20;
    localparam int ZCFG_W   = 7;
    localparam int PED_W    = 10;
    localparam int NOISE_W  = 10;
    localparam int PMD_W    = 10;
    localparam int PMA_W    = 10;
    localparam int FTHR_W   = 20;
    localparam int TCFG_W   = 18;
    localparam int DPCFG_W  = 12;
    localparam int MODE_W   = 8;
    localparam int VTHR_W   = 14;
    localparam int TRIG_W   = 16;
    localparam int BX_W     = 20;
    localparam int CHIPID_W = 5;
    localparam int ERR_W    = 3;

    // address map
    localparam logic [ADDR_W-1:0] A_ZTHR    = ADDR_W'(N_COEF);
    localparam logic [ADDR_W-1:0] A_ZCFG    = ADDR_W'(N_COEF + 1);
    localparam logic [ADDR_W-1:0] A_PED     = ADDR_W'(N_COEF + 2);
    localparam logic [ADDR_W-1:0] A_NOISE   = ADDR_W'(N_COEF + 3);
    localparam logic [ADDR_W-1:0] A_PMDATA  = ADDR_W'(N_COEF + 4);
    localparam logic [ADDR_W-1:0] A_PMADDR  = 5'h0D;
    localparam logic [ADDR_W-1:0] A_FTHR    = 5'h0E;
    localparam logic [ADDR_W-1:0] A_TCFG    = 5'h0F;
    localparam logic [ADDR_W-1:0] A_DPCFG   = 5'h10;
    localparam logic [ADDR_W-1:0] A_MODE    = 5'h11;
    localparam logic [ADDR_W-1:0] A_VTHR    = 5'h12;
    localparam logic [ADDR_W-1:0] A_TRIG    = 5'h13;
    localparam logic [ADDR_W-1:0] A_CHIPID  = 5'h14;
    localparam logic [ADDR_W-1:0] A_ERR     = 5'h15;
    localparam logic [ADDR_W-1:0] A_BX      = 5'h16;
    localparam logic [ADDR_W-1:0] A_CLRTRIG = 5'h1C;
    localparam logic [ADDR_W-1:0] A_CLRERR  = 5'h1D;
    localparam logic [ADDR_W-1:0] A_CLRBX   = 5'h1E;
    localparam logic [ADDR_W-1:0] A_SRST    = 5'h1F;

    // reset values
    localparam logic [ZTHR_W-1:0]  ZTHR_RST  = 20'h0000A;
    localparam logic [ZCFG_W-1:0]  ZCFG_RST  = 7'h7E;
    localparam logic [FTHR_W-1:0]  FTHR_RST  = 20'h40603;
    localparam logic [TCFG_W-1:0]  TCFG_RST  = 18'h3FD00;
    localparam logic [DPCFG_W-1:0] DPCFG_RST = 12'h000;
    localparam logic [MODE_W-1:0]  MODE_RST  = 8'hA4;
    localparam logic [VTHR_W-1:0]  VTHR_RST  = 14'h0463;

    localparam logic [7:0] TCFG_PRE_MAX = 8'd191;
    localparam logic [9:0] TCFG_SMP_MAX = 10'd1021;

    typedef struct packed {
        logic              we;
        logic              bcast;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } host_wr_t;

    typedef struct packed {
        logic clr_trig;
        logic clr_err;
        logic clr_bx;
        logic srst;
    } cmd_t;

    function automatic logic is_chan_addr(input logic [ADDR_W-1:0] a);
        return a <= A_PMDATA;
    endfunction

    function automatic logic [TCFG_W-1:0] clamp_tcfg(input logic [TCFG_W-1:0] d);
        logic [7:0] pre;
        logic [9:0] smp;
        pre = (d[7:0] > TCFG_PRE_MAX) ? TCFG_PRE_MAX : d[7:0];
        smp = (d[17:8] > TCFG_SMP_MAX) ? TCFG_SMP_MAX : d[17:8];
        return {smp, pre};
    endfunction
endpackage

// File: rtl/fe_chan_regs.sv
module fe_chan_regs
    import fe_cfg_pkg::*;
#(
    parameter int CH_ID = 0,
    parameter int CH_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  host_wr_t                 wr,
    input  logic [CH_W-1:0]          chan,
    output logic [N_COEF*COEF_W-1:0] o_coef,
    output logic [ZTHR_W-1:0]        o_zthr,
    output logic [ZCFG_W-1:0]        o_zcfg,
    output logic [PED_W-1:0]         o_ped,
    output logic [NOISE_W-1:0]       o_noise,
    output logic [DATA_W-1:0]        o_rd
);
    logic              sel;
    logic [COEF_W-1:0] coef_q [N_COEF];
    logic [PMD_W-1:0]  pmd_q;

    assign sel = wr.we && (wr.bcast || chan == CH_W'(CH_ID)) && is_chan_addr(wr.addr);

    for (genvar k = 0; k < N_COEF; k++) begin : g_coef
        always_ff @(posedge clk) begin
            if (rst)
                coef_q[k] <= '0;
            else if (sel && wr.addr == ADDR_W'(k))
                coef_q[k] <= wr.data[COEF_W-1:0];
        end
        assign o_coef[k*COEF_W +: COEF_W] = coef_q[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_zthr  <= ZTHR_RST;
            o_zcfg  <= ZCFG_RST;
            o_ped   <= '0;
            o_noise <= '0;
            pmd_q   <= '0;
        end else if (sel) begin
            case (wr.addr)
                A_ZTHR:   o_zthr  <= wr.data[ZTHR_W-1:0];
                A_ZCFG:   o_zcfg  <= wr.data[ZCFG_W-1:0];
                A_PED:    o_ped   <= wr.data[PED_W-1:0];
                A_NOISE:  o_noise <= wr.data[NOISE_W-1:0];
                A_PMDATA: pmd_q   <= wr.data[PMD_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        o_rd = '0;
        case (wr.addr)
            A_ZTHR:   o_rd = DATA_W'(o_zthr);
            A_ZCFG:   o_rd = DATA_W'(o_zcfg);
            A_PED:    o_rd = DATA_W'(o_ped);
            A_NOISE:  o_rd = DATA_W'(o_noise);
            A_PMDATA: o_rd = DATA_W'(pmd_q);
            default:
                if (wr.addr < A_ZTHR)
                    o_rd = DATA_W'(coef_q[wr.addr[COEF_IW-1:0]]);
        endcase
    end
endmodule

// File: rtl/fe_glob_regs.sv
module fe_glob_regs
    import fe_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  host_wr_t            wr,
    output logic [PMA_W-1:0]    o_pm_addr,
    output logic [FTHR_W-1:0]   o_filt_thr,
    output logic [TCFG_W-1:0]   o_trig_cfg,
    output logic [DPCFG_W-1:0]  o_dp_cfg,
    output logic [MODE_W-1:0]   o_mode,
    output logic [VTHR_W-1:0]   o_vp_thr,
    output logic [DATA_W-1:0]   o_rd
);
    logic wen;
    assign wen = wr.we && !wr.bcast;

    always_ff @(posedge clk) begin
        if (rst) begin
            o_pm_addr  <= '0;
            o_filt_thr <= FTHR_RST;
            o_trig_cfg <= TCFG_RST;
            o_dp_cfg   <= DPCFG_RST;
            o_mode     <= MODE_RST;
            o_vp_thr   <= VTHR_RST;
        end else if (wen) begin
            case (wr.addr)
                A_PMADDR: o_pm_addr  <= wr.data[PMA_W-1:0];
                A_FTHR:   o_filt_thr <= wr.data[FTHR_W-1:0];
                A_TCFG:   o_trig_cfg <= clamp_tcfg(wr.data[TCFG_W-1:0]);
                A_DPCFG:  o_dp_cfg   <= wr.data[DPCFG_W-1:0];
                A_MODE:   o_mode     <= wr.data[MODE_W-1:0];
                A_VTHR:   o_vp_thr   <= wr.data[VTHR_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (wr.addr)
            A_PMADDR: o_rd = DATA_W'(o_pm_addr);
            A_FTHR:   o_rd = DATA_W'(o_filt_thr);
            A_TCFG:   o_rd = DATA_W'(o_trig_cfg);
            A_DPCFG:  o_rd = DATA_W'(o_dp_cfg);
            A_MODE:   o_rd = DATA_W'(o_mode);
            A_VTHR:   o_rd = DATA_W'(o_vp_thr);
            default:  o_rd = '0;
        endcase
    end
endmodule

// File: rtl/fe_stat_ctrs.sv
module fe_stat_ctrs
    import fe_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic              i_trig,
    input  logic              i_bx,
    input  logic [ERR_W-1:0]  i_err,
    output logic [TRIG_W-1:0] o_trig_cnt,
    output logic [BX_W-1:0]   o_bx_cnt,
    output logic [ERR_W-1:0]  o_err
);
    always_ff @(posedge clk) begin
        if (rst || cmd.clr_trig)
            o_trig_cnt <= '0;
        else if (i_trig)
            o_trig_cnt <= o_trig_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.clr_bx)
            o_bx_cnt <= '0;
        else if (i_bx)
            o_bx_cnt <= o_bx_cnt + 1'b1;
    end

    for (genvar e = 0; e < ERR_W; e++) begin : g_err
        always_ff @(posedge clk) begin
            if (rst || cmd.clr_err)
                o_err[e] <= 1'b0;
            else if (i_err[e])
                o_err[e] <= 1'b1;
        end
    end
endmodule

// File: rtl/fe_cfg_regbank.sv
module fe_cfg_regbank
    import fe_cfg_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            i_we,
    input  logic                            i_re,
    input  logic                            i_bcast,
    input  logic [CH_W-1:0]                 i_chan,
    input  logic [ADDR_W-1:0]               i_addr,
    input  logic [DATA_W-1:0]               i_wdata,
    output logic [DATA_W-1:0]               o_rdata,
    input  logic                            i_trig,
    input  logic                            i_bx,
    input  logic                            i_err_par,
    input  logic                            i_err_instr,
    input  logic                            i_err_ovl,
    input  logic [CHIPID_W-1:0]             i_chip_id,
    output logic [NUM_CH*N_COEF*COEF_W-1:0] o_coef,
    output logic [NUM_CH*ZTHR_W-1:0]        o_zs_thr,
    output logic [NUM_CH*ZCFG_W-1:0]        o_zs_cfg,
    output logic [NUM_CH*PED_W-1:0]         o_ped,
    output logic [NUM_CH*NOISE_W-1:0]       o_noise,
    output logic [PMA_W-1:0]                o_pm_addr,
    output logic [PMD_W-1:0]                o_pm_data,
    output logic                            o_pm_we,
    output logic [FTHR_W-1:0]               o_filt_thr,
    output logic [TCFG_W-1:0]               o_trig_cfg,
    output logic [DPCFG_W-1:0]              o_dp_cfg,
    output logic [MODE_W-1:0]               o_mode,
    output logic [VTHR_W-1:0]               o_vp_thr
);
    localparam int CH_SLOTS = 1 << CH_W;

    host_wr_t          wr;
    cmd_t              cmd;
    logic              rst_all;
    logic [DATA_W-1:0] chan_rd [CH_SLOTS];
    logic [DATA_W-1:0] glob_rd;
    logic [DATA_W-1:0] rd_next;
    logic [TRIG_W-1:0] trig_cnt;
    logic [BX_W-1:0]   bx_cnt;
    logic [ERR_W-1:0]  err_q;

    assign wr = '{we: i_we, bcast: i_bcast, addr: i_addr, data: i_wdata};

    assign cmd.clr_trig = i_we && i_addr == A_CLRTRIG;
    assign cmd.clr_err  = i_we && i_addr == A_CLRERR;
    assign cmd.clr_bx   = i_we && i_addr == A_CLRBX;
    assign cmd.srst     = i_we && i_addr == A_SRST;
    assign rst_all      = rst || cmd.srst;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        fe_chan_regs #(.CH_ID(c), .CH_W(CH_W)) u_ch (
            .clk     (clk),
            .rst     (rst_all),
            .wr      (wr),
            .chan    (i_chan),
            .o_coef  (o_coef[c*N_COEF*COEF_W +: N_COEF*COEF_W]),
            .o_zthr  (o_zs_thr[c*ZTHR_W +: ZTHR_W]),
            .o_zcfg  (o_zs_cfg[c*ZCFG_W +: ZCFG_W]),
            .o_ped   (o_ped[c*PED_W +: PED_W]),
            .o_noise (o_noise[c*NOISE_W +: NOISE_W]),
            .o_rd    (chan_rd[c])
        );
    end
    for (genvar c = NUM_CH; c < CH_SLOTS; c++) begin : g_ch_none
        assign chan_rd[c] = '0;
    end

    fe_glob_regs u_glob (
        .clk        (clk),
        .rst        (rst_all),
        .wr         (wr),
        .o_pm_addr  (o_pm_addr),
        .o_filt_thr (o_filt_thr),
        .o_trig_cfg (o_trig_cfg),
        .o_dp_cfg   (o_dp_cfg),
        .o_mode     (o_mode),
        .o_vp_thr   (o_vp_thr),
        .o_rd       (glob_rd)
    );

    fe_stat_ctrs u_stat (
        .clk        (clk),
        .rst        (rst_all),
        .cmd        (cmd),
        .i_trig     (i_trig),
        .i_bx       (i_bx),
        .i_err      ({i_err_ovl, i_err_instr, i_err_par}),
        .o_trig_cnt (trig_cnt),
        .o_bx_cnt   (bx_cnt),
        .o_err      (err_q)
    );

    always_comb begin
        if (is_chan_addr(i_addr))
            rd_next = chan_rd[i_chan];
        else begin
            case (i_addr)
                A_TRIG:   rd_next = DATA_W'(trig_cnt);
                A_CHIPID: rd_next = DATA_W'(i_chip_id);
                A_ERR:    rd_next = DATA_W'(err_q);
                A_BX:     rd_next = DATA_W'(bx_cnt);
                default:  rd_next = glob_rd;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst_all) begin
            o_rdata   <= '0;
            o_pm_we   <= 1'b0;
            o_pm_data <= '0;
        end else begin
            if (i_re)
                o_rdata <= rd_next;
            o_pm_we <= i_we && i_addr == A_PMDATA;
            if (i_we && i_addr == A_PMDATA)
                o_pm_data <= i_wdata[PMD_W-1:0];
        end
    end
endmodule

// File: rtl/fe_cfg_chk.sv
module fe_cfg_chk
    import fe_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              i_we,
    input logic              i_bcast,
    input logic [ADDR_W-1:0] i_addr,
    input logic              i_trig,
    input logic [TRIG_W-1:0] trig_cnt,
    input logic [ERR_W-1:0]  err_q,
    input logic [PMA_W-1:0]  o_pm_addr,
    input logic [FTHR_W-1:0] o_filt_thr,
    input logic [TCFG_W-1:0] o_trig_cfg,
    input logic [DPCFG_W-1:0] o_dp_cfg,
    input logic [MODE_W-1:0] o_mode,
    input logic [VTHR_W-1:0] o_vp_thr,
    input logic              o_pm_we
);
    logic glob_bc, trig_clr, err_clr, pm_wr;
    assign glob_bc  = i_we && i_bcast && i_addr >= A_PMADDR && i_addr <= A_VTHR;
    assign trig_clr = i_we && (i_addr == A_CLRTRIG || i_addr == A_SRST);
    assign err_clr  = i_we && (i_addr == A_CLRERR || i_addr == A_SRST);
    assign pm_wr    = i_we && i_addr == A_PMDATA;

    a_r4_bcast_global_hold: assert property (@(posedge clk) disable iff (rst)
        glob_bc |=> $stable({o_pm_addr, o_filt_thr, o_trig_cfg, o_dp_cfg, o_mode, o_vp_thr}));

    a_r5_tcfg_limits: assert property (@(posedge clk) disable iff (rst)
        (o_trig_cfg[7:0] <= TCFG_PRE_MAX) && (o_trig_cfg[17:8] <= TCFG_SMP_MAX));

    a_r7_trig_step: assert property (@(posedge clk) disable iff (rst)
        (i_trig && !trig_clr) |=> trig_cnt == TRIG_W'($past(trig_cnt) + 1'b1));

    a_r7_trig_clear_wins: assert property (@(posedge clk) disable iff (rst)
        trig_clr |=> trig_cnt == '0);

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        !err_clr |=> ($past(err_q) & ~err_q) == '0);

    a_r10_srst_defaults: assert property (@(posedge clk) disable iff (rst)
        (i_we && i_addr == A_SRST) |=> (o_mode == MODE_RST && o_trig_cfg == TCFG_RST && err_q == '0));

    a_r11_pm_strobe_on: assert property (@(posedge clk) disable iff (rst)
        pm_wr |=> o_pm_we);

    a_r11_pm_strobe_off: assert property (@(posedge clk) disable iff (rst)
        !pm_wr |=> !o_pm_we);
endmodule

bind fe_cfg_regbank fe_cfg_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .i_we       (i_we),
    .i_bcast    (i_bcast),
    .i_addr     (i_addr),
    .i_trig     (i_trig),
    .trig_cnt   (trig_cnt),
    .err_q      (err_q),
    .o_pm_addr  (o_pm_addr),
    .o_filt_thr (o_filt_thr),
    .o_trig_cfg (o_trig_cfg),
    .o_dp_cfg   (o_dp_cfg),
    .o_mode     (o_mode),
    .o_vp_thr   (o_vp_thr),
    .o_pm_we    (o_pm_we)
);

// File: tb/sim_fe_cfg_regbank.sv
module sim_fe_cfg_regbank;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int CHW = 2;
    localparam int CW  = 13;
    localparam int CPC = 8 * CW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic i_we = 1'b0, i_re = 1'b0, i_bcast = 1'b0;
    logic [CHW-1:0] i_chan = '0;
    logic [4:0]  i_addr = '0;
    logic [19:0] i_wdata = '0;
    logic [19:0] o_rdata;
    logic i_trig = 1'b0, i_bx = 1'b0;
    logic i_err_par = 1'b0, i_err_instr = 1'b0, i_err_ovl = 1'b0;
    logic [4:0] i_chip_id = 5'h15;
    logic [NCH*CPC-1:0] o_coef;
    logic [NCH*20-1:0]  o_zs_thr;
    logic [NCH*7-1:0]   o_zs_cfg;
    logic [NCH*10-1:0]  o_ped;
    logic [NCH*10-1:0]  o_noise;
    logic [9:0]  o_pm_addr, o_pm_data;
    logic        o_pm_we;
    logic [19:0] o_filt_thr;
    logic [17:0] o_trig_cfg;
    logic [11:0] o_dp_cfg;
    logic [7:0]  o_mode;
    logic [13:0] o_vp_thr;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [19:0] exp_q[$];
    string       tag_q[$];
    logic        rd_pend = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fe_cfg_regbank #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst(rst), .i_we(i_we), .i_re(i_re), .i_bcast(i_bcast),
        .i_chan(i_chan), .i_addr(i_addr), .i_wdata(i_wdata), .o_rdata(o_rdata),
        .i_trig(i_trig), .i_bx(i_bx), .i_err_par(i_err_par),
        .i_err_instr(i_err_instr), .i_err_ovl(i_err_ovl), .i_chip_id(i_chip_id),
        .o_coef(o_coef), .o_zs_thr(o_zs_thr), .o_zs_cfg(o_zs_cfg), .o_ped(o_ped),
        .o_noise(o_noise), .o_pm_addr(o_pm_addr), .o_pm_data(o_pm_data),
        .o_pm_we(o_pm_we), .o_filt_thr(o_filt_thr), .o_trig_cfg(o_trig_cfg),
        .o_dp_cfg(o_dp_cfg), .o_mode(o_mode), .o_vp_thr(o_vp_thr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [CHW-1:0] c,
                      input logic bc, input logic [19:0] d);
        @(negedge clk);
        i_we = 1'b1; i_addr = a; i_chan = c; i_bcast = bc; i_wdata = d;
        @(negedge clk);
        i_we = 1'b0; i_bcast = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [CHW-1:0] c,
                      input logic [19:0] exp, input string tag);
        @(negedge clk);
        i_re = 1'b1; i_addr = a; i_chan = c;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        i_re = 1'b0;
    endtask

    task automatic pulse_err(input int which);
        @(negedge clk);
        if (which == 0) i_err_par = 1'b1;
        if (which == 1) i_err_instr = 1'b1;
        if (which == 2) i_err_ovl = 1'b1;
        @(negedge clk);
        i_err_par = 1'b0; i_err_instr = 1'b0; i_err_ovl = 1'b0;
    endtask

    always @(posedge clk) rd_pend <= i_re;

    // scoreboard monitor
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R6: act=unexpected read exp=none");
            end else begin
                logic [19:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, 32'(o_rdata), 32'(e));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: act=timeout exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 zs_thr ch0", 32'(o_zs_thr[0 +: 20]), 32'h0000A);
        chk("R1 zs_thr ch3", 32'(o_zs_thr[60 +: 20]), 32'h0000A);
        chk("R1 zs_cfg ch2", 32'(o_zs_cfg[14 +: 7]), 32'h7E);
        chk("R1 coef all", 32'(|o_coef), 32'h0);
        chk("R1 noise/ped", 32'(|{o_noise, o_ped, o_pm_addr}), 32'h0);
        chk("R1 filt_thr", 32'(o_filt_thr), 32'h40603);
        chk("R1 trig_cfg", 32'(o_trig_cfg), 32'h3FD00);
        chk("R1 dp_cfg", 32'(o_dp_cfg), 32'h0);
        chk("R1 mode", 32'(o_mode), 32'hA4);
        chk("R1 vp_thr", 32'(o_vp_thr), 32'h463);

        // R2 addressed write, one channel only
        wr(5'h03, 2'd2, 1'b0, 20'h01ABC);
        chk("R2 coef3 ch2", 32'(o_coef[2*CPC + 3*CW +: CW]), 32'h1ABC);
        chk("R2 coef3 ch1", 32'(o_coef[1*CPC + 3*CW +: CW]), 32'h0);
        rd(5'h03, 2'd2, 20'h01ABC, "R2 read coef3 ch2");
        rd(5'h03, 2'd3, 20'h00000, "R2 read coef3 ch3");

        // R3 broadcast write to per-channel register
        wr(5'h0B, 2'd0, 1'b1, 20'h002A5);
        for (int c = 0; c < NCH; c++)
            chk("R3 bcast noise", 32'(o_noise[c*10 +: 10]), 32'h2A5);
        rd(5'h0B, 2'd3, 20'h002A5, "R3 read noise ch3");

        // R4 global register ignores broadcast
        wr(5'h11, 2'd0, 1'b1, 20'h00000);
        chk("R4 bcast mode held", 32'(o_mode), 32'hA4);
        wr(5'h11, 2'd1, 1'b0, 20'hFFF13);
        chk("R4 mode write", 32'(o_mode), 32'h13);
        rd(5'h11, 2'd0, 20'h00013, "R4 read mode");

        // R5 trigger window clamping
        wr(5'h0F, 2'd0, 1'b0, 20'h3E8C8);
        chk("R5 pre clamp", 32'(o_trig_cfg), 32'h3E8BF);
        wr(5'h0F, 2'd0, 1'b0, 20'h3FF05);
        chk("R5 samples clamp", 32'(o_trig_cfg), 32'h3FD05);

        // R6 read map
        rd(5'h14, 2'd0, 20'h00015, "R6 chip id");
        rd(5'h19, 2'd0, 20'h00000, "R6 unused reads zero");
        rd(5'h1C, 2'd0, 20'h00000, "R6 command reads zero");
        rd(5'h09, 2'd1, 20'h0007E, "R6 zs_cfg ch1");

        // R7 counters
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); i_trig = 1'b1; i_bx = 1'b1;
            @(negedge clk); i_trig = 1'b0; i_bx = (i < 2);
            @(negedge clk); i_bx = 1'b0;
        end
        // trig pulses 3, bx pulses 3 + 2 = 5
        rd(5'h13, 2'd0, 20'h00003, "R7 trig count");
        rd(5'h16, 2'd0, 20'h00005, "R7 bx count");
        @(negedge clk);
        i_we = 1'b1; i_addr = 5'h1C; i_wdata = 20'h0; i_trig = 1'b1;
        @(negedge clk);
        i_we = 1'b0; i_trig = 1'b0;
        rd(5'h13, 2'd0, 20'h00000, "R7 clear wins over increment");
        @(negedge clk);
        i_trig = 1'b1; i_bx = 1'b1;
        repeat (65537) @(negedge clk);
        i_trig = 1'b0; i_bx = 1'b0;
        rd(5'h13, 2'd0, 20'h00001, "R7 trig wrap");
        rd(5'h16, 2'd0, 20'h10006, "R7 bx count long");
        wr(5'h1E, 2'd0, 1'b0, 20'h12345);
        rd(5'h16, 2'd0, 20'h00000, "R7 bx clear");

        // R8 sticky errors
        pulse_err(0);
        repeat (3) @(negedge clk);
        rd(5'h15, 2'd0, 20'h00001, "R8 parity sticky");
        pulse_err(2);
        rd(5'h15, 2'd0, 20'h00005, "R8 overlap sticky");
        @(negedge clk);
        i_we = 1'b1; i_addr = 5'h1D; i_wdata = 20'hFFFFF; i_err_instr = 1'b1;
        @(negedge clk);
        i_we = 1'b0; i_err_instr = 1'b0;
        rd(5'h15, 2'd0, 20'h00000, "R8 clear wins over set");
        pulse_err(1);
        rd(5'h15, 2'd0, 20'h00002, "R8 instr sticky");

        // R9 ignored writes and data-independent commands
        wr(5'h13, 2'd0, 1'b0, 20'hFFFFF);
        rd(5'h13, 2'd0, 20'h00001, "R9 read-only trig held");
        wr(5'h17, 2'd0, 1'b0, 20'hFFFFF);
        chk("R9 unused write mode held", 32'(o_mode), 32'h13);
        wr(5'h1B, 2'd0, 1'b0, 20'hFFFFF);
        chk("R9 cmd 0x1B trig_cfg held", 32'(o_trig_cfg), 32'h3FD05);
        rd(5'h15, 2'd0, 20'h00002, "R9 cmd 0x1B errors held");
        wr(5'h1D, 2'd0, 1'b0, 20'h00000);
        rd(5'h15, 2'd0, 20'h00000, "R9 clear with zero data");

        // R11 pedestal memory strobe
        wr(5'h0D, 2'd0, 1'b0, 20'h00155);
        wr(5'h0C, 2'd1, 1'b0, 20'h000AA);
        chk("R11 pm strobe high", 32'(o_pm_we), 32'h1);
        chk("R11 pm data", 32'(o_pm_data), 32'h0AA);
        chk("R11 pm addr", 32'(o_pm_addr), 32'h155);
        @(negedge clk);
        chk("R11 pm strobe one cycle", 32'(o_pm_we), 32'h0);
        rd(5'h0C, 2'd1, 20'h000AA, "R11 read pm data ch1");

        // R10 software reset
        @(negedge clk); i_err_ovl = 1'b1;
        @(negedge clk); i_err_ovl = 1'b0;
        wr(5'h1F, 2'd0, 1'b0, 20'h00000);
        chk("R10 mode default", 32'(o_mode), 32'hA4);
        chk("R10 trig_cfg default", 32'(o_trig_cfg), 32'h3FD00);
        chk("R10 pm addr default", 32'(o_pm_addr), 32'h0);
        chk("R10 coef cleared", 32'(|o_coef), 32'h0);
        chk("R10 zs_thr default ch1", 32'(o_zs_thr[20 +: 20]), 32'h0000A);
        rd(5'h13, 2'd0, 20'h00000, "R10 trig cleared");
        rd(5'h15, 2'd0, 20'h00000, "R10 errors cleared");
        rd(5'h0B, 2'd2, 20'h00000, "R10 noise cleared");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R6: act=%0d pending reads exp=0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule